// File: doc/BRIEF.md
# Serialized Interrupt Slave Agent

This block lets a device report up to sixteen interrupt request levels and one I/O error-check level over a single shared, open-collector interrupt line. The line is clocked by the bus clock. The block drives the line through a drive-enable and drive-value pair and observes it through a sampled input. A host controller frames each reporting cycle with a long start pulse and a short stop pulse. The agent counts three-clock slots from the rising edge of the start pulse. In the sample phase of each slot it pulls the line low when the matching input is low. It then restores the line high and releases it.

The width of the stop pulse tells the agent whether the next cycle is host-paced (continuous) or request-paced (quiet). In quiet mode the agent may open a cycle itself when an input has changed and has not been reported yet. It does this with a one-clock low pulse, which the host then stretches into a full start pulse. Input levels pass through a two-flop synchronizer before use.

Top module: `serirq_slave`

## Requirements
- R1: While reset is active, and after it, the drive enable is low. After reset the agent is in continuous mode and does not open a cycle when an input changes.
- R2: Clock 0 is the first cycle in which the line is high after a start pulse. For a slot of frame n (1 to 17), the agent drives the line low in clock 3n-1 if that slot's input is low. If the input is high, the line stays released. Frame n carries irq_lvl[n-1] for n up to 16.
- R3: In clock 3n the agent drives the line high, but only if it drove low in clock 3n-1. In clock 3n+1 it releases the line. The line is never driven in clock 1.
- R4: Frames 1 and 3 (irq_lvl[0] and irq_lvl[2]) are never driven, whatever their input level.
- R5: Frame 17 carries iochk_lvl, driven low in clock 50 when that input is low.
- R6: After frame 17, a low pulse of exactly two clocks selects quiet mode for the following cycle, and a low pulse of exactly three clocks selects continuous mode.
- R7: In quiet mode, with the line idle and an unreported change pending, the agent drives the line low for exactly one clock and then releases it without driving high. For a change made while idle, that clock is the third cycle after the input changes, because of the synchronizer.
- R8: After a stop pulse, the earliest self-started low is in the second clock after the line rises again.
- R9: A change reported in its slot of the cycle already under way needs no further start. A change that arrives after its slot has passed is reported by a new start after the stop pulse.
- R10: In continuous mode the agent never opens a cycle, even with changes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl | input | NUM_IRQ | Interrupt levels; low means report low in the slot |
| iochk_lvl | input | 1 | I/O error-check level, reported in frame 17 |
| sirq_in | input | 1 | Sampled level of the shared interrupt line |
| sirq_oe | output | 1 | Drive enable for the line (1 = drive) |
| sirq_out | output | 1 | Value driven when sirq_oe is high |

## Verification
The bench sweeps walking-zero and dense patterns across every slot and checks each of the 52 counted clocks. A one-clock error in slot alignment, or a recovery-phase drive that does not follow a low, shows up as a wrong drive phase. It also checks that the two reserved frames stay silent even when their inputs are low. Stop pulses of two and three clocks are alternated, and the bench watches the idle line afterwards. A design that decodes the stop width wrongly would start cycles in continuous mode or stay silent in quiet mode. A design that ignores the recovery gap would pull the line low one clock too early. Changes placed before and after their slot within a cycle separate a design that drops late changes from one that issues redundant starts.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_SLOTS = 2'd2,
        ST_STOP  = 2'd3
    } sq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_RECOV  = 2'd1,
        PH_TURN   = 2'd2
    } sq_phase_e;

    typedef enum logic {
        MODE_CONT  = 1'b0,
        MODE_QUIET = 1'b1
    } sq_mode_e;

    localparam int unsigned STOP_QUIET_CLKS = 2;
    localparam int unsigned STOP_CONT_CLKS  = 3;
    localparam int unsigned LOWCNT_W        = 3;

    // slots 0 and 2 carry no report
    function automatic logic slot_reported(int unsigned idx);
        return !(idx == 0 || idx == 2);
    endfunction

endpackage

// File: rtl/serirq_sync.sv
module serirq_sync #(
    parameter int   W       = 17,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/serirq_pending.sv
module serirq_pending
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS = 17,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] slot_lvl,
    input  logic                 load_en,
    input  logic [IDX_W-1:0]     load_idx,
    output logic                 pend_any
);
    logic [NUM_SLOTS-1:0] sent_q;
    logic [NUM_SLOTS-1:0] used_mask;
    logic [NUM_SLOTS-1:0] pend_vec;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign used_mask[i] = slot_reported(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                sent_q[i] <= 1'b1;
            end else if (load_en && (load_idx == IDX_W'(i))) begin
                sent_q[i] <= slot_lvl[i];
            end
        end
    end

    assign pend_vec = (slot_lvl ^ sent_q) & used_mask;
    assign pend_any = |pend_vec;

    // R9
    // a slot that was just reported with a stable level is no longer pending
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && $stable(slot_lvl)) |=> !pend_vec[$past(load_idx)]);
endmodule

// File: rtl/serirq_frame_fsm.sv
module serirq_frame_fsm
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS = 17,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int FR_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_in,
    input  logic [NUM_SLOTS-1:0] slot_lvl,
    input  logic                 pend_any,
    output logic                 load_en,
    output logic [IDX_W-1:0]     load_idx,
    output logic                 drv_oe,
    output logic                 drv_val
);
    sq_state_e            state_q;
    sq_phase_e            phase_q;
    sq_mode_e             mode_q;
    logic [FR_W-1:0]      frame_q;
    logic                 drove_q;
    logic [LOWCNT_W-1:0]  lowcnt_q;
    logic [NUM_SLOTS-1:0] used_mask;
    logic                 hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_used
        assign used_mask[i] = slot_reported(i);
    end

    assign load_en  = (state_q == ST_SLOTS) && (phase_q == PH_SAMPLE);
    assign load_idx = IDX_W'(frame_q - FR_W'(1));
    assign hit      = used_mask[load_idx] & ~slot_lvl[load_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_TURN;
            mode_q   <= MODE_CONT;
            frame_q  <= '0;
            drove_q  <= 1'b0;
            lowcnt_q <= '0;
            drv_oe   <= 1'b0;
            drv_val  <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    drv_oe  <= 1'b0;
                    drv_val <= 1'b1;
                    if (!line_in) begin
                        state_q <= ST_LOW;
                    end else if (mode_q == MODE_QUIET && pend_any) begin
                        drv_oe  <= 1'b1;
                        drv_val <= 1'b0;
                        state_q <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    drv_oe  <= 1'b0;
                    drv_val <= 1'b1;
                    if (line_in) begin
                        state_q <= ST_SLOTS;
                        frame_q <= FR_W'(1);
                        phase_q <= PH_SAMPLE;
                    end
                end
                ST_SLOTS: begin
                    unique case (phase_q)
                        PH_SAMPLE: begin
                            drove_q <= hit;
                            drv_oe  <= hit;
                            drv_val <= 1'b0;
                            phase_q <= PH_RECOV;
                        end
                        PH_RECOV: begin
                            drv_oe  <= drove_q;
                            drv_val <= 1'b1;
                            phase_q <= PH_TURN;
                        end
                        default: begin
                            drv_oe  <= 1'b0;
                            drv_val <= 1'b1;
                            if (frame_q == FR_W'(NUM_SLOTS)) begin
                                state_q  <= ST_STOP;
                                lowcnt_q <= '0;
                            end else begin
                                frame_q <= frame_q + FR_W'(1);
                                phase_q <= PH_SAMPLE;
                            end
                        end
                    endcase
                end
                default: begin
                    drv_oe  <= 1'b0;
                    drv_val <= 1'b1;
                    if (!line_in) begin
                        if (lowcnt_q != {LOWCNT_W{1'b1}}) begin
                            lowcnt_q <= lowcnt_q + LOWCNT_W'(1);
                        end
                    end else if (lowcnt_q != '0) begin
                        if (lowcnt_q == LOWCNT_W'(STOP_QUIET_CLKS)) begin
                            mode_q <= MODE_QUIET;
                        end else if (lowcnt_q == LOWCNT_W'(STOP_CONT_CLKS)) begin
                            mode_q <= MODE_CONT;
                        end
                        lowcnt_q <= '0;
                        state_q  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R1
    reset_release_chk: assert property (@(posedge clk)
        rst |=> !drv_oe);

    // R3
    recov_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_oe && drv_val) |-> $past(drv_oe && !drv_val));

    // R3
    turn_release_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_oe && drv_val) |=> !drv_oe);

    // R7
    single_low_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_oe && !drv_val) |=> !(drv_oe && !drv_val));

    // R6
    mode_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> ($past(state_q) == ST_STOP));

    // R10
    cont_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && mode_q == MODE_CONT) |=> !drv_oe);
endmodule

// File: rtl/serirq_slave.sv
module serirq_slave
    import serirq_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_lvl,
    input  logic               iochk_lvl,
    input  logic               sirq_in,
    output logic               sirq_oe,
    output logic               sirq_out
);
    localparam int NUM_SLOTS = NUM_IRQ + 1;
    localparam int IDX_W     = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0] slot_lvl;
    logic                 pend_any;
    logic                 load_en;
    logic [IDX_W-1:0]     load_idx;

    serirq_sync #(
        .W       (NUM_SLOTS),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({iochk_lvl, irq_lvl}),
        .q   (slot_lvl)
    );

    serirq_pending #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_pending (
        .clk      (clk),
        .rst      (rst),
        .slot_lvl (slot_lvl),
        .load_en  (load_en),
        .load_idx (load_idx),
        .pend_any (pend_any)
    );

    serirq_frame_fsm #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .line_in  (sirq_in),
        .slot_lvl (slot_lvl),
        .pend_any (pend_any),
        .load_en  (load_en),
        .load_idx (load_idx),
        .drv_oe   (sirq_oe),
        .drv_val  (sirq_out)
    );
endmodule

// File: tb/serirq_slave_tb.sv
module serirq_slave_tb;
    localparam int NIRQ = 16;
    localparam int LAST_CLK = 52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NIRQ-1:0] irq = '1;
    logic iochk = 1'b1;
    logic host_low = 1'b0;
    logic sirq_in;
    logic sirq_oe;
    logic sirq_out;
    int   errs = 0;
    int   checks = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    assign sirq_in = ((sirq_oe && !sirq_out) || host_low) ? 1'b0 : 1'b1;

    serirq_slave #(.NUM_IRQ(NIRQ)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_lvl   (irq),
        .iochk_lvl (iochk),
        .sirq_in   (sirq_in),
        .sirq_oe   (sirq_oe),
        .sirq_out  (sirq_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit used(input int s);
        return !(s == 0 || s == 2);
    endfunction

    function automatic bit slot_val(input int s);
        return (s < NIRQ) ? irq[s] : iochk;
    endfunction

    task automatic set_slot(input int s, input bit v);
        if (s < NIRQ) irq[s] = v;
        else iochk = v;
    endtask

    task automatic set_all(input logic [NIRQ:0] v);
        irq   = v[NIRQ-1:0];
        iochk = v[NIRQ];
    endtask

    function automatic int drv_code();
        return sirq_oe ? (sirq_out ? 2 : 1) : 0;
    endfunction

    // drive code: 0 released, 1 low, 2 high
    task automatic host_frames(input int start_rem, input int stop_len, input int chg_clk,
                               input int chg_idx, input bit after_self);
        bit prev_low = 1'b0;
        for (int i = 0; i < start_rem; i++) begin
            @(negedge clk);
            if (i == 0 && after_self)
                chk(!sirq_oe, "R7", drv_code(), 0, "line after self start");
            host_low = 1'b1;
        end
        @(negedge clk);
        host_low = 1'b0;
        for (int c = 1; c <= LAST_CLK; c++) begin
            @(negedge clk);
            if (c % 3 == 2) begin
                int  s = (c + 1) / 3 - 1;
                bit  e = used(s) && !slot_val(s);
                string rq = (s == NIRQ) ? "R5" : (!used(s) ? "R4" : "R2");
                prev_low = e;
                chk(drv_code() == (e ? 1 : 0), rq, drv_code(), e ? 1 : 0,
                    $sformatf("sample clock %0d slot %0d", c, s));
            end else if (c % 3 == 0) begin
                chk(drv_code() == (prev_low ? 2 : 0), "R3", drv_code(), prev_low ? 2 : 0,
                    $sformatf("recovery clock %0d", c));
            end else begin
                chk(drv_code() == 0, "R3", drv_code(), 0,
                    $sformatf("turnaround clock %0d", c));
            end
            if (c == chg_clk) set_slot(chg_idx, 1'b0);
        end
        for (int i = 0; i < stop_len; i++) begin
            @(negedge clk);
            host_low = 1'b1;
            chk(!sirq_oe, "R6", drv_code(), 0, "line during stop");
        end
        @(negedge clk);
        host_low = 1'b0;
        chk(!sirq_oe, "R8", drv_code(), 0, "stop rise clock");
    endtask

    task automatic quiet_watch(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!sirq_oe, req, drv_code(), 0, "idle line");
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        // R1: released through reset
        repeat (4) begin
            @(negedge clk);
            chk(!sirq_oe, "R1", drv_code(), 0, "reset");
        end
        @(negedge clk);
        rst = 1'b0;
        irq[3] = 1'b0;
        quiet_watch(20, "R1");

        // R2 R3 R4 R5 R10: pattern sweep with continuous stops
        for (int p = 0; p < 21; p++) begin
            logic [NIRQ:0] v;
            if (p == 0) v = '1;
            else if (p == 1) v = '0;
            else if (p == 2) v = 17'h0AAAA;
            else if (p == 3) v = 17'h15555;
            else begin
                v = '1;
                v[p-4] = 1'b0;
            end
            @(negedge clk);
            set_all(v);
            settle();
            host_frames(4, 3, -1, 0, 1'b0);
            quiet_watch(3, "R10");
        end

        // R6: stop of two selects quiet; nothing pending -> no start (R9)
        @(negedge clk);
        set_all('1);
        settle();
        host_frames(4, 2, -1, 0, 1'b0);
        quiet_watch(12, "R9");

        // R7: idle change triggers one-clock self start in third cycle
        @(negedge clk);
        irq[9] = 1'b0;
        @(negedge clk);
        chk(!sirq_oe, "R7", drv_code(), 0, "one cycle after change");
        @(negedge clk);
        chk(!sirq_oe, "R7", drv_code(), 0, "two cycles after change");
        @(negedge clk);
        chk(sirq_oe && !sirq_out, "R6", drv_code(), 1, "self start in quiet mode");
        host_frames(3, 2, -1, 0, 1'b1);
        quiet_watch(8, "R9");

        // R9: change before its slot delivered in same cycle, no new start
        host_frames(4, 2, 5, 5, 1'b0);
        quiet_watch(10, "R9");

        // R8 R9: change after its slot -> start two clocks after stop rise
        host_frames(4, 2, 30, 4, 1'b0);
        @(negedge clk);
        chk(!sirq_oe, "R8", drv_code(), 0, "first clock after stop rise");
        @(negedge clk);
        chk(sirq_oe && !sirq_out, "R9", drv_code(), 1, "start for late change");
        host_frames(3, 3, -1, 0, 1'b1);

        // R6 R10: stop of three returns to continuous mode
        @(negedge clk);
        irq[7] = 1'b0;
        quiet_watch(20, "R10");
        host_frames(4, 2, -1, 0, 1'b0);
        quiet_watch(6, "R6");

        done = 1'b1;
        finish_run();
    end
endmodule